// File: doc/BRIEF.md
# UART Modem Line Control and Status

This block holds the handshake side of a serial port. A control register written by the host drives the two outgoing handshake lines (terminal-ready and request-to-send, both active low). A status register reports the four incoming handshake lines (clear-to-send, data-set-ready, ring indicator and carrier detect, all active low). Each incoming line passes through a synchronizer. Every change of a line raises a sticky delta flag, and reading the status register clears the flags. A single "status changed" output is raised while any flag is set, so that an interrupt combiner elsewhere can use it.

Two control bits gate the reported ring and carrier levels. While a gate bit is 0, the matching level bit reads 0 whatever the pin does. A loopback bit holds both outgoing pins inactive and feeds the four status inputs from control bits. Two further bits select hardware flow control, which is active only when both are 1. A three-state machine turns that selection into a transmit-allowed signal. Its states are FL_FREE (hardware flow control off, transmit always allowed), FL_STALL (hardware flow control on, clear-to-send inactive, transmit held) and FL_GO (hardware flow control on, clear-to-send active). Transitions: FREE goes to GO or STALL when hardware mode turns on, depending on clear-to-send. STALL goes to GO when clear-to-send asserts. GO goes to STALL when clear-to-send drops. STALL and GO both return to FREE when hardware mode turns off.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the control register reads 0x00, both outgoing pins are high, the status register reads 0x00, the change output is 0 and transmit is allowed.
- R2: Outside loopback, control bit 0 drives the terminal-ready pin and bit 1 drives the request-to-send pin, each pin being the inverse of its bit.
- R3: Status bits 4, 5, 6 and 7 report clear-to-send, data-set-ready, ring and carrier as 1 when the pin is low. A pin change shows there two clock edges later, through the synchronizer.
- R4: While control bit 2 is 0, status bit 6 reads 0. While control bit 3 is 0, status bit 7 reads 0. Gating does not set a delta flag.
- R5: Status bits 0, 1, 2 and 3 are set by any change of the clear-to-send, data-set-ready, ring or carrier level (before gating). A flag stays set until a status read.
- R6: A one-cycle status read strobe clears all delta flags, and the change output is the OR of the four flags.
- R7: A level change detected in the same cycle as a status read leaves its flag set after the read.
- R8: While control bit 4 is 1, both outgoing pins are high and the external inputs are ignored. Clear-to-send follows bit 1, data-set-ready follows bit 0, ring follows bit 2 and carrier follows bit 3.
- R9: While control bits 6 and 7 are both 1, transmit-allowed follows the clear-to-send level one clock edge after that level changes. Otherwise transmit is allowed.
- R10: A control write stores all bits except bit 5, which always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| sts_rd | input | 1 | Status read strobe, clears delta flags |
| sts_rdata | output | 8 | Status register value |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| msc | output | 1 | Modem status changed |
| tx_ok | output | 1 | Transmitter may start a new character |

## Verification
The sharpest corner is a line change that lands in the same cycle as a status read. A design that lets the clear win loses that event and returns 0xE0 where 0xE2 is due. The bench opens and closes the ring and carrier gates with the pins held. A design that took its deltas from gated levels would raise spurious flags, and one that ignored the gates would report levels that should read 0. In loopback the bench toggles an external pin to confirm it has no effect, and it swaps the control bits to catch a crossed mapping between request-to-send and terminal-ready. For flow control the bench samples transmit-allowed one cycle before and one cycle after it should change, which exposes a missing or extra register stage.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int unsigned REG_W     = 8;
    localparam int unsigned LINES     = 4;

    localparam int unsigned C_DTR     = 0;
    localparam int unsigned C_RTS     = 1;
    localparam int unsigned C_RI_GATE = 2;
    localparam int unsigned C_CD_GATE = 3;
    localparam int unsigned C_LOOP    = 4;
    localparam int unsigned C_RSVD    = 5;
    localparam int unsigned C_HWFC    = 6;
    localparam int unsigned C_MDM_EN  = 7;

    localparam int unsigned L_CTS     = 0;
    localparam int unsigned L_DSR     = 1;
    localparam int unsigned L_RI      = 2;
    localparam int unsigned L_CD      = 3;

    typedef enum logic [1:0] {
        FL_FREE  = 2'd0,
        FL_STALL = 2'd1,
        FL_GO    = 2'd2
    } flow_st_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic         clr,
    output logic [W-1:0] flags
);
    logic [W-1:0] lvl_q;
    logic [W-1:0] chg;

    assign chg = lvl ^ lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            flags <= '0;
        end else begin
            lvl_q <= lvl;
            flags <= (clr ? '0 : flags) | chg;
        end
    end

    // R6
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && chg == '0) |=> (flags == '0));

    // R7
    change_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg != '0) |=> ((flags & $past(chg)) == $past(chg)));

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/mdm_flow.sv
module mdm_flow
    import mdm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_mode,
    input  logic cts_act,
    output logic tx_ok
);
    flow_st_t st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FL_FREE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            FL_FREE: begin
                if (hw_mode) nxt = cts_act ? FL_GO : FL_STALL;
            end
            FL_STALL: begin
                if (!hw_mode)    nxt = FL_FREE;
                else if (cts_act) nxt = FL_GO;
            end
            FL_GO: begin
                if (!hw_mode)     nxt = FL_FREE;
                else if (!cts_act) nxt = FL_STALL;
            end
            default: nxt = FL_FREE;
        endcase
    end

    always_comb begin
        tx_ok = (st != FL_STALL);
    end

    // R9
    sw_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_mode |=> tx_ok);

    // R9
    hw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_mode && !cts_act) |=> !tx_ok);
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import mdm_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [REG_W-1:0] ctl_wdata,
    output logic [REG_W-1:0] ctl_rdata,
    input  logic             sts_rd,
    output logic [REG_W-1:0] sts_rdata,
    input  logic             cts_n,
    input  logic             dsr_n,
    input  logic             ri_n,
    input  logic             dcd_n,
    output logic             dtr_n,
    output logic             rts_n,
    output logic             msc,
    output logic             tx_ok
);
    localparam logic [REG_W-1:0] WR_MASK = ~(REG_W'(1) << C_RSVD);

    logic [REG_W-1:0] ctl_q;
    logic [LINES-1:0] pin_raw, pin_s;
    logic [LINES-1:0] ext_lvl, loop_lvl, lvl, gate, rep;
    logic [LINES-1:0] dlt;
    logic             loop_on, hw_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ctl_wdata & WR_MASK;
    end

    assign loop_on = ctl_q[C_LOOP];
    assign hw_mode = ctl_q[C_HWFC] & ctl_q[C_MDM_EN];

    assign dtr_n = loop_on | ~ctl_q[C_DTR];
    assign rts_n = loop_on | ~ctl_q[C_RTS];

    assign pin_raw[L_CTS] = cts_n;
    assign pin_raw[L_DSR] = dsr_n;
    assign pin_raw[L_RI]  = ri_n;
    assign pin_raw[L_CD]  = dcd_n;

    mdm_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_raw),
        .dout (pin_s)
    );

    assign ext_lvl = ~pin_s;

    assign loop_lvl[L_CTS] = ctl_q[C_RTS];
    assign loop_lvl[L_DSR] = ctl_q[C_DTR];
    assign loop_lvl[L_RI]  = ctl_q[C_RI_GATE];
    assign loop_lvl[L_CD]  = ctl_q[C_CD_GATE];

    assign lvl = loop_on ? loop_lvl : ext_lvl;

    assign gate[L_CTS] = 1'b1;
    assign gate[L_DSR] = 1'b1;
    assign gate[L_RI]  = ctl_q[C_RI_GATE];
    assign gate[L_CD]  = ctl_q[C_CD_GATE];

    assign rep = lvl & gate;

    mdm_delta #(.W(LINES)) u_delta (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .clr  (sts_rd),
        .flags(dlt)
    );

    mdm_flow u_flow (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_mode(hw_mode),
        .cts_act(lvl[L_CTS]),
        .tx_ok  (tx_ok)
    );

    assign sts_rdata = {rep, dlt};
    assign ctl_rdata = ctl_q;
    assign msc       = |dlt;

    // R8
    loop_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[C_LOOP] |-> (dtr_n && rts_n));

    // R4
    ri_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[C_RI_GATE] |-> !sts_rdata[6]);

    // R4
    cd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[C_CD_GATE] |-> !sts_rdata[7]);

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> !ctl_rdata[C_RSVD]);
endmodule

// File: tb/sim_uart_modem_ctl.sv
module sim_uart_modem_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       sts_rd = 1'b0;
    logic [7:0] sts_rdata;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic       dtr_n, rts_n, msc, tx_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    uart_modem_ctl u0 (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .sts_rd(sts_rd), .sts_rdata(sts_rdata),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .dtr_n(dtr_n), .rts_n(rts_n), .msc(msc), .tx_ok(tx_ok)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        tick(1);
        ctl_wr = 1'b0;
    endtask

    task automatic rd_sts();
        sts_rd = 1'b1;
        tick(1);
        sts_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 ctl", ctl_rdata, 8'h00);
        check("R1 pins", {6'd0, dtr_n, rts_n}, 8'h03);
        check("R1 sts", sts_rdata, 8'h00);
        check("R1 msc/tx", {6'd0, msc, tx_ok}, 8'h01);
    endtask

    task automatic t_ctl();
        wr_ctl(8'h03);
        check("R2 both on", {6'd0, dtr_n, rts_n}, 8'h00);
        wr_ctl(8'h01);
        check("R2 dtr only", {6'd0, dtr_n, rts_n}, 8'h01);
        wr_ctl(8'hFF);
        check("R10 rsvd", ctl_rdata, 8'hDF);
        tick(2);
        wr_ctl(8'h00);
        tick(2);
        rd_sts();
        check("R6 cleared", sts_rdata, 8'h00);
        check("R6 msc low", {7'd0, msc}, 8'h00);
    endtask

    task automatic t_levels();
        wr_ctl(8'h0C);
        cts_n = 1'b0; dsr_n = 1'b1; ri_n = 1'b0; dcd_n = 1'b1;
        tick(1);
        check("R3 not yet", sts_rdata, 8'h00);
        tick(3);
        check("R3 R5 levels", sts_rdata, 8'h55);
        check("R6 msc high", {7'd0, msc}, 8'h01);
        rd_sts();
        check("R6 read", sts_rdata, 8'h50);
        check("R6 msc drop", {7'd0, msc}, 8'h00);
        dcd_n = 1'b0; cts_n = 1'b1;
        tick(4);
        check("R5 second", sts_rdata, 8'hC9);
        rd_sts();
        check("R6 read2", sts_rdata, 8'hC0);
    endtask

    task automatic t_gating();
        wr_ctl(8'h00);
        check("R4 both gated", sts_rdata, 8'h00);
        wr_ctl(8'h04);
        check("R4 ri open", sts_rdata, 8'h40);
        wr_ctl(8'h08);
        tick(1);
        check("R4 cd open", sts_rdata, 8'h80);
        wr_ctl(8'h0C);
    endtask

    task automatic t_collision();
        dsr_n = 1'b0;
        tick(2);
        sts_rd = 1'b1;
        tick(1);
        sts_rd = 1'b0;
        check("R7 kept", sts_rdata, 8'hE2);
        rd_sts();
        check("R7 then clear", sts_rdata, 8'hE0);
    endtask

    task automatic t_loop();
        wr_ctl(8'h1D);
        check("R8 pins idle", {6'd0, dtr_n, rts_n}, 8'h03);
        tick(2);
        check("R8 map a", sts_rdata, 8'hE0);
        wr_ctl(8'h1E);
        tick(2);
        check("R8 map b", sts_rdata, 8'hD3);
        cts_n = 1'b0;
        tick(4);
        check("R8 ext ignored", sts_rdata, 8'hD3);
        rd_sts();
        wr_ctl(8'h0C);
        tick(2);
        rd_sts();
        check("R8 exit", sts_rdata, 8'hF0);
        cts_n = 1'b1;
        tick(4);
        rd_sts();
    endtask

    task automatic t_flow();
        wr_ctl(8'hCC);
        tick(1);
        check("R9 stall", {7'd0, tx_ok}, 8'h00);
        cts_n = 1'b0;
        tick(2);
        check("R9 still stalled", {7'd0, tx_ok}, 8'h00);
        tick(1);
        check("R9 go", {7'd0, tx_ok}, 8'h01);
        cts_n = 1'b1;
        tick(4);
        check("R9 stall again", {7'd0, tx_ok}, 8'h00);
        wr_ctl(8'h4C);
        tick(1);
        check("R9 modem off", {7'd0, tx_ok}, 8'h01);
        wr_ctl(8'h8C);
        tick(1);
        check("R9 sw mode", {7'd0, tx_ok}, 8'h01);
        wr_ctl(8'hCC);
        tick(1);
        check("R9 hw back", {7'd0, tx_ok}, 8'h00);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_ctl();
        t_levels();
        t_gating();
        t_collision();
        t_loop();
        t_flow();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule